// File: doc/BRIEF.md
# Five-Level Carrier PWM Modulator with Dead-Time Gating

This block turns three signed phase references into five-level pole commands for a three-phase multilevel inverter. A single up/down triangular counter serves as the carrier. Each reference is captured only when the carrier reaches a turning point. A shared common-mode offset is then added so that the three references sit centred in the output range. Each adjusted reference is split into a whole number of carrier bands, which gives the base level, and a remainder within the band. Only the remainder is compared against the carrier. The output is the base level, or one above it. One comparator per phase therefore does the work of four stacked carrier comparisons.

Each phase level is expanded into four leg commands in thermometer form. Every leg drives a complementary gate pair through a dead-time state machine. The carrier state machine has two states, `CAR_RISE` and `CAR_FALL`. It moves from rising to falling on reaching the all-ones count, and from falling to rising on reaching zero. The dead-time machine has five states: `DT_BOOT`, `DT_LOW`, `DT_GAP_UP`, `DT_HIGH` and `DT_GAP_DN`. Its transitions are:

- `DT_BOOT` goes to `DT_LOW` or `DT_HIGH` when its count expires, choosing by the command.
- `DT_LOW` goes to `DT_GAP_UP` when the command rises.
- `DT_GAP_UP` goes to `DT_HIGH` when the count expires, or back to `DT_LOW` if the command falls first.
- `DT_HIGH` goes to `DT_GAP_DN` when the command falls.
- `DT_GAP_DN` goes to `DT_LOW` when the count expires, or back to `DT_HIGH` if the command rises first.

Top module: `mlpwm_modulator`

## Requirements
- R1: `carrier_o` resets to 0 and steps by exactly one every clock. It counts up to 2^CAR_W-1, then down to 0, then repeats.
- R2: The three references are captured only on clock edges where the carrier value before the edge is 0 or 2^CAR_W-1. At all other times the captured values hold.
- R3: With B = 2^CAR_W, each captured reference r is adjusted to r + 2B - floor((max+min)/2), where max and min are taken over the three captured references. Three equal references therefore give level 2 on every phase.
- R4: An adjusted reference below 0 is treated as 0, and one above 4B is treated as 4B.
- R5: A phase level is the adjusted value divided by B (the base), plus one if the remainder is strictly greater than the current carrier value. A base of 4 gives level 4. Level n on `lvl_x_o` means n quarters of the DC link.
- R6: Gate pair index 4p+k (phase a is p=0, b is p=1, c is p=2; k = 0..3) is commanded high when that phase's level is greater than k.
- R7: The two gates of a pair are never both on. When a pair's command changes, both gates stay off for exactly DEAD_CYC cycles before the new gate turns on. The gate outputs follow the command with one register.
- R8: A command pulse of DEAD_CYC cycles or fewer produces no pulse on the opposite gate. The previous gate returns as soon as the command reverts.
- R9: After reset, `carrier_o` is 0, all levels are 2 and every gate is off. The gates stay off for DEAD_CYC clock edges, then each pair turns on the side its command selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_a_i | input | REF_W | Phase a reference, signed, nominal span -2B to +2B |
| ref_b_i | input | REF_W | Phase b reference, signed |
| ref_c_i | input | REF_W | Phase c reference, signed |
| carrier_o | output | CAR_W | Triangular carrier count |
| lvl_a_o | output | 3 | Phase a level, 0 to 4 |
| lvl_b_o | output | 3 | Phase b level, 0 to 4 |
| lvl_c_o | output | 3 | Phase c level, 0 to 4 |
| gate_hi_o | output | 12 | Upper gate of each leg pair, index 4p+k |
| gate_lo_o | output | 12 | Lower gate of each leg pair, index 4p+k |

## Verification
The hardest case to reach from the ports is a leg command whose pulse is just at or just above the dead time. That command must come out of the offset and band translation with a remainder of only one to three counts, and the pulse must sit around the carrier valley. The stimulus gets there by applying references +f, -f and 0. This pins the offset so that phase a lands exactly f counts into band two. The bench then counts upper-gate cycles over one carrier period aligned to the peak. A mid-period reference change is also placed at a known carrier count, to show that nothing moves until the next turning point.

// File: rtl/mlpwm_pkg.sv
package mlpwm_pkg;

    localparam int unsigned PHASES = 3;
    localparam int unsigned LEGS   = 4;

    typedef enum logic [0:0] {
        CAR_RISE,
        CAR_FALL
    } car_dir_e;

    typedef enum logic [2:0] {
        DT_BOOT,
        DT_LOW,
        DT_GAP_UP,
        DT_HIGH,
        DT_GAP_DN
    } dt_state_e;

endpackage

// File: rtl/mlpwm_carrier.sv
module mlpwm_carrier
    import mlpwm_pkg::*;
#(
    parameter int unsigned CAR_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    output logic [CAR_W-1:0] cnt_o,
    output logic             turn_o
);

    localparam logic [CAR_W-1:0] TOP = '1;

    car_dir_e         dir_q, dir_d;
    logic [CAR_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            dir_q <= CAR_RISE;
            cnt_q <= '0;
        end else begin
            dir_q <= dir_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        dir_d = dir_q;
        cnt_d = cnt_q;
        unique case (dir_q)
            CAR_RISE: begin
                if (cnt_q == TOP) begin
                    dir_d = CAR_FALL;
                    cnt_d = cnt_q - 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            CAR_FALL: begin
                if (cnt_q == '0) begin
                    dir_d = CAR_RISE;
                    cnt_d = cnt_q + 1'b1;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                dir_d = CAR_RISE;
                cnt_d = '0;
            end
        endcase
    end

    always_comb begin
        cnt_o  = cnt_q;
        turn_o = (cnt_q == TOP) || (cnt_q == '0);
    end

endmodule

// File: rtl/mlpwm_cm_shift.sv
module mlpwm_cm_shift
    import mlpwm_pkg::*;
#(
    parameter int unsigned CAR_W = 8,
    parameter int unsigned REF_W = CAR_W + 3
) (
    input  logic [PHASES*REF_W-1:0] ref_i,
    output logic [PHASES*3-1:0]     base_o,
    output logic [PHASES*CAR_W-1:0] frac_o
);

    localparam int unsigned EW = REF_W + 3;
    localparam int unsigned AW = CAR_W + 3;
    localparam logic signed [EW-1:0] MID  = EW'(2 ** (CAR_W + 1));
    localparam logic signed [EW-1:0] FULL = EW'(2 ** (CAR_W + 2));

    logic signed [EW-1:0] r    [PHASES];
    logic signed [EW-1:0] adj  [PHASES];
    logic        [AW-1:0] adju [PHASES];
    logic signed [EW-1:0] mx, mn, half;

    always_comb begin
        for (int p = 0; p < PHASES; p++) begin
            r[p] = EW'($signed(ref_i[p*REF_W +: REF_W]));
        end
        mx = r[0];
        mn = r[0];
        for (int p = 1; p < PHASES; p++) begin
            if (r[p] > mx) mx = r[p];
            if (r[p] < mn) mn = r[p];
        end
        half = (mx + mn) >>> 1;
        for (int p = 0; p < PHASES; p++) begin
            adj[p] = r[p] + MID - half;
            if (adj[p] < 0) begin
                adju[p] = '0;
            end else if (adj[p] > FULL) begin
                adju[p] = FULL[AW-1:0];
            end else begin
                adju[p] = adj[p][AW-1:0];
            end
            base_o[p*3 +: 3]         = adju[p][AW-1:CAR_W];
            frac_o[p*CAR_W +: CAR_W] = adju[p][CAR_W-1:0];
        end
    end

endmodule

// File: rtl/mlpwm_deadtime.sv
module mlpwm_deadtime
    import mlpwm_pkg::*;
#(
    parameter int unsigned DEAD_CYC = 150
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic cmd_i,
    output logic hi_o,
    output logic lo_o
);

    localparam int unsigned CW = (DEAD_CYC > 1) ? $clog2(DEAD_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(DEAD_CYC - 1);

    dt_state_e     st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          done;

    assign done = (cnt_q == LAST);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q  <= DT_BOOT;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            DT_BOOT: begin
                if (done) begin
                    st_d  = cmd_i ? DT_HIGH : DT_LOW;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            DT_LOW: begin
                if (cmd_i) begin
                    st_d  = DT_GAP_UP;
                    cnt_d = '0;
                end
            end
            DT_GAP_UP: begin
                if (!cmd_i) begin
                    st_d = DT_LOW;
                end else if (done) begin
                    st_d = DT_HIGH;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            DT_HIGH: begin
                if (!cmd_i) begin
                    st_d  = DT_GAP_DN;
                    cnt_d = '0;
                end
            end
            DT_GAP_DN: begin
                if (cmd_i) begin
                    st_d = DT_HIGH;
                end else if (done) begin
                    st_d = DT_LOW;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                st_d  = DT_BOOT;
                cnt_d = '0;
            end
        endcase
    end

    always_comb begin
        hi_o = (st_q == DT_HIGH);
        lo_o = (st_q == DT_LOW);
    end

endmodule

// File: rtl/mlpwm_modulator.sv
module mlpwm_modulator
    import mlpwm_pkg::*;
#(
    parameter int unsigned CAR_W    = 8,
    parameter int unsigned REF_W    = CAR_W + 3,
    parameter int unsigned DEAD_CYC = 150
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic signed [REF_W-1:0] ref_a_i,
    input  logic signed [REF_W-1:0] ref_b_i,
    input  logic signed [REF_W-1:0] ref_c_i,
    output logic [CAR_W-1:0]        carrier_o,
    output logic [2:0]              lvl_a_o,
    output logic [2:0]              lvl_b_o,
    output logic [2:0]              lvl_c_o,
    output logic [PHASES*LEGS-1:0]  gate_hi_o,
    output logic [PHASES*LEGS-1:0]  gate_lo_o
);

    logic [CAR_W-1:0]        cnt;
    logic                    turn;
    logic [PHASES*REF_W-1:0] ref_q;
    logic [PHASES*3-1:0]     base;
    logic [PHASES*CAR_W-1:0] frac;
    logic [PHASES*3-1:0]     lvl_v;

    mlpwm_carrier #(.CAR_W(CAR_W)) car_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .cnt_o (cnt),
        .turn_o(turn)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ref_q <= '0;
        end else if (turn) begin
            ref_q <= {ref_c_i, ref_b_i, ref_a_i};
        end
    end

    mlpwm_cm_shift #(.CAR_W(CAR_W), .REF_W(REF_W)) shift_i (
        .ref_i (ref_q),
        .base_o(base),
        .frac_o(frac)
    );

    for (genvar p = 0; p < PHASES; p++) begin : g_phase
        assign lvl_v[p*3 +: 3] = (base[p*3 +: 3] >= 3'd4) ? 3'd4 :
                                 base[p*3 +: 3] + {2'b00, (frac[p*CAR_W +: CAR_W] > cnt)};
        for (genvar k = 0; k < LEGS; k++) begin : g_leg
            mlpwm_deadtime #(.DEAD_CYC(DEAD_CYC)) dt_i (
                .clk_i (clk_i),
                .rst_ni(rst_ni),
                .cmd_i (lvl_v[p*3 +: 3] > 3'(k)),
                .hi_o  (gate_hi_o[p*LEGS + k]),
                .lo_o  (gate_lo_o[p*LEGS + k])
            );
        end
    end

    assign carrier_o = cnt;
    assign lvl_a_o   = lvl_v[2:0];
    assign lvl_b_o   = lvl_v[5:3];
    assign lvl_c_o   = lvl_v[8:6];

endmodule

// File: rtl/mlpwm_checker.sv
module mlpwm_checker #(
    parameter int unsigned CAR_W = 8,
    parameter int unsigned NG    = 12
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [CAR_W-1:0] carrier_i,
    input logic [2:0]       lvl_a_i,
    input logic [2:0]       lvl_b_i,
    input logic [2:0]       lvl_c_i,
    input logic [NG-1:0]    gate_hi_i,
    input logic [NG-1:0]    gate_lo_i
);

    AST_GATE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((gate_hi_i & gate_lo_i) == '0)); // R7

    AST_HI_AFTER_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> ((gate_hi_i & $past(gate_lo_i)) == '0)); // R7

    AST_LO_AFTER_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> ((gate_lo_i & $past(gate_hi_i)) == '0)); // R7

    AST_CARRIER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> (((carrier_i - $past(carrier_i)) == CAR_W'(1)) ||
                           (($past(carrier_i) - carrier_i) == CAR_W'(1)))); // R1

    AST_LEVEL_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lvl_a_i <= 3'd4) && (lvl_b_i <= 3'd4) && (lvl_c_i <= 3'd4)); // R5

endmodule

bind mlpwm_modulator mlpwm_checker #(.CAR_W(CAR_W), .NG(PHASES*LEGS)) chk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .carrier_i(carrier_o),
    .lvl_a_i  (lvl_a_o),
    .lvl_b_i  (lvl_b_o),
    .lvl_c_i  (lvl_c_o),
    .gate_hi_i(gate_hi_o),
    .gate_lo_i(gate_lo_o)
);

// File: tb/mlpwm_modulator_tb_top.sv
`timescale 1ns/1ps
module mlpwm_modulator_tb_top;

    localparam int CAR_W  = 6;
    localparam int REF_W  = 9;
    localparam int DEAD   = 3;
    localparam int B      = 64;
    localparam int MAXC   = 63;
    localparam int PERIOD = 126;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic signed [REF_W-1:0] ra, rb, rc;
    logic [CAR_W-1:0] carrier;
    logic [2:0] la, lb, lc;
    logic [11:0] ghi, glo;

    always #10 clk = ~clk;

    mlpwm_modulator #(.CAR_W(CAR_W), .REF_W(REF_W), .DEAD_CYC(DEAD)) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .ref_a_i(ra), .ref_b_i(rb), .ref_c_i(rc),
        .carrier_o(carrier),
        .lvl_a_o(la), .lvl_b_o(lb), .lvl_c_o(lc),
        .gate_hi_o(ghi), .gate_lo_o(glo)
    );

    int checks = 0;
    int fails  = 0;
    int mref[3];
    int drv[3];
    int elv[3];
    int mcar;
    bit mup;
    int gst[12];
    int gcnt[12];
    bit pleg[12];
    int hi_count[12];

    function automatic int exp_lvl(int r, int mx, int mn, int car);
        int adj;
        adj = r + 2 * B - ((mx + mn) >>> 1);
        if (adj < 0) adj = 0;
        if (adj > 4 * B) adj = 4 * B;
        if (adj / B >= 4) return 4;
        return adj / B + (((adj % B) > car) ? 1 : 0);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int lvl_out(int p);
        if (p == 0) return int'(la);
        if (p == 1) return int'(lb);
        return int'(lc);
    endfunction

    task automatic cycle(int a, int b, int c);
        int mx, mn;
        ra = REF_W'(a); rb = REF_W'(b); rc = REF_W'(c);
        drv[0] = a; drv[1] = b; drv[2] = c;
        @(negedge clk);
        if (mcar == 0 || mcar == MAXC) begin
            for (int p = 0; p < 3; p++) mref[p] = drv[p];
        end
        if (mup) begin
            if (mcar == MAXC) begin mup = 1'b0; mcar--; end else mcar++;
        end else begin
            if (mcar == 0) begin mup = 1'b1; mcar++; end else mcar--;
        end
        for (int i = 0; i < 12; i++) begin
            case (gst[i])
                0: if (gcnt[i] == DEAD - 1) begin gst[i] = pleg[i] ? 3 : 1; gcnt[i] = 0; end
                   else gcnt[i]++;
                1: if (pleg[i]) begin gst[i] = 2; gcnt[i] = 0; end
                2: if (!pleg[i]) gst[i] = 1;
                   else if (gcnt[i] == DEAD - 1) gst[i] = 3;
                   else gcnt[i]++;
                3: if (!pleg[i]) begin gst[i] = 4; gcnt[i] = 0; end
                default: if (pleg[i]) gst[i] = 3;
                   else if (gcnt[i] == DEAD - 1) gst[i] = 1;
                   else gcnt[i]++;
            endcase
        end
        chk(int'(carrier) == mcar, "R1", "carrier", int'(carrier), mcar);
        mx = mref[0]; mn = mref[0];
        for (int p = 1; p < 3; p++) begin
            if (mref[p] > mx) mx = mref[p];
            if (mref[p] < mn) mn = mref[p];
        end
        for (int p = 0; p < 3; p++) begin
            elv[p] = exp_lvl(mref[p], mx, mn, mcar);
            chk(lvl_out(p) == elv[p], "R5", "level", lvl_out(p), elv[p]);
        end
        for (int i = 0; i < 12; i++) begin
            chk(ghi[i] == (gst[i] == 3), "R7", "gate_hi bit", int'(ghi[i]), int'(gst[i] == 3));
            chk(glo[i] == (gst[i] == 1), "R7", "gate_lo bit", int'(glo[i]), int'(gst[i] == 1));
            hi_count[i] += int'(ghi[i]);
        end
        for (int p = 0; p < 3; p++) begin
            for (int k = 0; k < 4; k++) pleg[p*4+k] = (elv[p] > k);
        end
    endtask

    task automatic run(int n, int a, int b, int c);
        for (int i = 0; i < n; i++) cycle(a, b, c);
    endtask

    initial begin
        #3000000;
        chk(1'b0, "R1", "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F2E));
        ra = '0; rb = '0; rc = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int p = 0; p < 3; p++) mref[p] = 0;
        mcar = 0; mup = 1'b1;
        for (int i = 0; i < 12; i++) begin
            gst[i] = 0; gcnt[i] = 0; hi_count[i] = 0;
            pleg[i] = ((i % 4) < 2);
        end
        #1;
        // R9 reset state
        chk(carrier == '0, "R9", "carrier at reset", int'(carrier), 0);
        chk(la == 3'd2 && lb == 3'd2 && lc == 3'd2, "R9", "level a at reset", int'(la), 2);
        chk((ghi | glo) == '0, "R9", "gates at reset", int'(ghi | glo), 0);
        run(DEAD - 1, 0, 0, 0);
        chk((ghi | glo) == '0, "R9", "gates during boot gap", int'(ghi | glo), 0);
        run(1, 0, 0, 0);
        chk(ghi == 12'h333, "R9", "gate_hi after boot gap", int'(ghi), 'h333);
        chk(glo == 12'hCCC, "R6", "gate_lo after boot gap", int'(glo), 'hCCC);

        // R3 equal references sit at mid level
        run(2 * PERIOD + 5, 100, 100, 100);
        chk(la == 3'd2 && lb == 3'd2 && lc == 3'd2, "R3", "equal refs level a", int'(la), 2);
        run(2 * PERIOD + 7, -150, -150, -150);
        chk(la == 3'd2 && lb == 3'd2 && lc == 3'd2, "R3", "equal negative refs level a", int'(la), 2);

        // R2 mid-period change is not taken
        while (!(mup && mcar == 20)) cycle(-150, -150, -150);
        for (int i = 0; i < 4; i++) begin
            cycle(255, -256, -256);
            chk(la == 3'd2, "R2", "level a before turning point", int'(la), 2);
        end
        // R4 clamping at both ends
        run(2 * PERIOD, 255, -256, -256);
        chk(la == 3'd4, "R4", "clamped high level a", int'(la), 4);
        chk(lb == 3'd0 && lc == 3'd0, "R4", "clamped low level b", int'(lb), 0);
        run(DEAD + 2, 255, -256, -256);
        chk(ghi[3:0] == 4'hF, "R6", "phase a upper gates", int'(ghi[3:0]), 15);
        chk(glo[7:4] == 4'hF, "R6", "phase b lower gates", int'(glo[7:4]), 15);
        chk(ghi[11:8] == 4'h0, "R6", "phase c upper gates", int'(ghi[11:8]), 0);

        // R8 short pulses around the valley on phase a leg 2
        for (int f = 1; f <= 4; f++) begin
            int w;
            run(2 * PERIOD, f, -f, 0);
            while (mcar != MAXC) cycle(f, -f, 0);
            hi_count[2] = 0;
            run(PERIOD, f, -f, 0);
            w = 2 * f - 1;
            chk(hi_count[2] == ((w > DEAD) ? w - DEAD : 0), "R8", "leg pulse cycles",
                hi_count[2], (w > DEAD) ? w - DEAD : 0);
        end

        // random references held for random spans
        for (int n = 0; n < 80; n++) begin
            int len, a, b, c;
            len = $urandom_range(1, 300);
            a = int'($urandom_range(0, 511)) - 256;
            b = int'($urandom_range(0, 511)) - 256;
            c = int'($urandom_range(0, 511)) - 256;
            run(len, a, b, c);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule